// File: doc/BRIEF.md
# Domain Access Checker

This block decides whether a bus master may touch a peripheral. Every master is first placed in one of four access domains. Every peripheral then carries a policy word: a 2-bit permission for each domain, a flag saying that a hardware semaphore must be held before access, and a lock bit. When a master presents a peripheral index and a read/write flag, the block finds the master's domain, selects that domain's permission from the peripheral's policy, and answers allow or deny in the same cycle. The answer comes with the peripheral's semaphore-required flag.

Configuration uses a simple register port. A write takes effect on the next clock edge, and reads return data combinationally. A status register reports the domain of the master that is currently using the configuration port. The master assignments and the peripheral policies each have a sticky lock bit. Once that bit is set, writes to the entry are ignored until the next reset, so boot software can fix the partitioning and later software cannot change it.

Register map, by `cfg_addr`: addresses 0 to 7 hold the master assignments, addresses 8 to 23 hold the peripheral policies (peripheral p at 8+p), and address 24 is the status register. Addresses 25 to 31 are unmapped.

Top module: `domain_access_checker`

## Requirements
- R1: After reset, every master assignment reads 0x00000000 (domain 0, unlocked). Every peripheral policy reads 0x000000FF, which gives read and write to all four domains with the semaphore flag and the lock clear.
- R2: A master assignment word keeps the domain in bits [1:0] and the lock in bit 31. All other bits read as 0, whatever was written to them.
- R3: A peripheral policy word keeps domain d's permission in bits [2d+1:2d] for d = 0..3, the semaphore-required flag in bit 30 and the lock in bit 31. All other bits read as 0.
- R4: Once a master assignment has its lock bit set, every later write to it is ignored until reset, including writes that try to clear the lock.
- R5: Once a peripheral policy has its lock bit set, every later write to it is ignored until reset.
- R6: Permission code 0 denies everything, 1 allows only writes, 2 allows only reads and 3 allows both. `chk_allow` reflects the inputs in the same cycle, with no register on the path.
- R7: The permission used is the field of the requesting master's current domain. Masters in the same domain get identical answers, and moving a master to another domain changes its answers on the next cycle.
- R8: `chk_sem_req` equals bit 30 of the addressed peripheral's policy, whether or not the access is allowed.
- R9: Reading address 24 returns the domain of `cfg_mid` in bits [1:0] and zeros elsewhere. Writes to address 24 and to addresses 25 to 31 change nothing, and reads from addresses 25 to 31 return 0.
- R10: A configuration write changes only the addressed register. With `cfg_we` low, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_mid | input | 3 | Master currently using the configuration port |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| chk_mid | input | 3 | Master ID of the access being checked |
| chk_pidx | input | 4 | Peripheral index of the access being checked |
| chk_write | input | 1 | 1 for a write access, 0 for a read access |
| chk_allow | output | 1 | Access permitted |
| chk_sem_req | output | 1 | Peripheral requires a semaphore to be held |

## Verification
The bench targets the permission codes that allow only one direction. A design that swapped the read and write bits would allow a read on a write-only peripheral, and the bench's checks on codes 1 and 2 would catch it. It writes a locked entry again, including a write that clears the lock; a lock that is not sticky would let the domain or policy change, and the read-back would show it. It moves a master between domains and compares against a second master in the same domain, which exposes a lookup keyed by master instead of domain. It also writes to the status register and to the unmapped addresses, then checks that no table entry moved, which catches a decoder that aliases those addresses onto a real register.

// File: rtl/dac_pkg.sv
`timescale 1ns/1ps
package dac_pkg;
    localparam int DOM_W    = 2;
    localparam int N_DOM    = 1 << DOM_W;
    localparam int PERM_W   = 2;
    localparam int POL_W    = N_DOM * PERM_W;
    localparam int REG_W    = 32;
    localparam int LOCK_POS = 31;
    localparam int SEM_POS  = 30;
    // bit positions inside one permission field
    localparam int P_WRITE  = 0;
    localparam int P_READ   = 1;

    typedef logic [DOM_W-1:0] dom_t;

    typedef struct packed {
        logic lock;
        dom_t dom;
    } mst_ent_t;

    typedef struct packed {
        logic             lock;
        logic             sem;
        logic [POL_W-1:0] perm;
    } pol_ent_t;

    localparam pol_ent_t POL_RST = '{lock: 1'b0, sem: 1'b0, perm: {POL_W{1'b1}}};
endpackage

// File: rtl/dac_master_table.sv
`timescale 1ns/1ps
module dac_master_table
    import dac_pkg::*;
#(
    parameter int N_MASTERS = 8,
    localparam int IDX_W = $clog2(N_MASTERS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  dom_t                       wr_dom,
    input  logic                       wr_lock,
    output mst_ent_t [N_MASTERS-1:0]   tab_o
);
    typedef struct packed {
        mst_ent_t [N_MASTERS-1:0] tab;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_MASTERS; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i)) && !st_q.tab[i].lock) begin
                st_d.tab[i].dom  = wr_dom;
                st_d.tab[i].lock = wr_lock;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tab_o = st_q.tab;
endmodule

// File: rtl/dac_policy_table.sv
`timescale 1ns/1ps
module dac_policy_table
    import dac_pkg::*;
#(
    parameter int N_PERIPH = 16,
    localparam int IDX_W = $clog2(N_PERIPH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  pol_ent_t                  wr_ent,
    output pol_ent_t [N_PERIPH-1:0]   tab_o
);
    typedef struct packed {
        pol_ent_t [N_PERIPH-1:0] tab;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_PERIPH; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i)) && !st_q.tab[i].lock) begin
                st_d.tab[i] = wr_ent;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tab <= {N_PERIPH{POL_RST}};
        end else begin
            st_q <= st_d;
        end
    end

    assign tab_o = st_q.tab;
endmodule

// File: rtl/dac_lookup.sv
`timescale 1ns/1ps
module dac_lookup
    import dac_pkg::*;
#(
    parameter int N_MASTERS = 8,
    parameter int N_PERIPH  = 16,
    localparam int MID_W  = $clog2(N_MASTERS),
    localparam int PIDX_W = $clog2(N_PERIPH)
) (
    input  mst_ent_t [N_MASTERS-1:0] mst_tab,
    input  pol_ent_t [N_PERIPH-1:0]  pol_tab,
    input  logic [MID_W-1:0]         mid,
    input  logic [PIDX_W-1:0]        pidx,
    input  logic                     is_write,
    output logic                     allow,
    output logic                     sem_req
);
    dom_t              dom;
    pol_ent_t          pol;
    logic [PERM_W-1:0] perm;
    logic              in_range;
    logic              unused_locks;

    always_comb begin
        in_range = (int'(mid) < N_MASTERS) && (int'(pidx) < N_PERIPH);
        dom      = in_range ? mst_tab[mid].dom : '0;
        pol      = in_range ? pol_tab[pidx] : '0;
        perm     = pol.perm[int'(dom)*PERM_W +: PERM_W];
        allow    = in_range && (is_write ? perm[P_WRITE] : perm[P_READ]);
        sem_req  = pol.sem;
        unused_locks = pol.lock;
        for (int i = 0; i < N_MASTERS; i++) begin
            unused_locks = unused_locks ^ mst_tab[i].lock;
        end
    end
endmodule

// File: rtl/domain_access_checker.sv
`timescale 1ns/1ps
module domain_access_checker
    import dac_pkg::*;
#(
    parameter int N_MASTERS = 8,
    parameter int N_PERIPH  = 16,
    localparam int MID_W     = $clog2(N_MASTERS),
    localparam int PIDX_W    = $clog2(N_PERIPH),
    localparam int STAT_ADDR = N_MASTERS + N_PERIPH,
    localparam int AW        = $clog2(STAT_ADDR + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic [MID_W-1:0]  cfg_mid,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic [MID_W-1:0]  chk_mid,
    input  logic [PIDX_W-1:0] chk_pidx,
    input  logic              chk_write,
    output logic              chk_allow,
    output logic              chk_sem_req
);
    mst_ent_t [N_MASTERS-1:0] mst_tab;
    pol_ent_t [N_PERIPH-1:0]  pol_tab;

    logic              hit_mst, hit_pol, hit_stat;
    logic [MID_W-1:0]  mst_idx;
    logic [PIDX_W-1:0] pol_idx;
    logic [AW-1:0]     pol_off;
    pol_ent_t          wr_pol;
    logic              unused_wdata;

    // address decode
    always_comb begin
        hit_mst  = int'(cfg_addr) < N_MASTERS;
        hit_pol  = (int'(cfg_addr) >= N_MASTERS) && (int'(cfg_addr) < STAT_ADDR);
        hit_stat = int'(cfg_addr) == STAT_ADDR;
        pol_off  = cfg_addr - AW'(N_MASTERS);
        mst_idx  = MID_W'(cfg_addr);
        pol_idx  = PIDX_W'(pol_off);
        wr_pol   = '{lock: cfg_wdata[LOCK_POS], sem: cfg_wdata[SEM_POS],
                     perm: cfg_wdata[POL_W-1:0]};
        unused_wdata = ^cfg_wdata[SEM_POS-1:POL_W];
    end

    dac_master_table #(.N_MASTERS(N_MASTERS)) u_mst (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we && hit_mst),
        .wr_idx  (mst_idx),
        .wr_dom  (cfg_wdata[DOM_W-1:0]),
        .wr_lock (cfg_wdata[LOCK_POS]),
        .tab_o   (mst_tab)
    );

    dac_policy_table #(.N_PERIPH(N_PERIPH)) u_pol (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we && hit_pol),
        .wr_idx (pol_idx),
        .wr_ent (wr_pol),
        .tab_o  (pol_tab)
    );

    dac_lookup #(.N_MASTERS(N_MASTERS), .N_PERIPH(N_PERIPH)) u_look (
        .mst_tab  (mst_tab),
        .pol_tab  (pol_tab),
        .mid      (chk_mid),
        .pidx     (chk_pidx),
        .is_write (chk_write),
        .allow    (chk_allow),
        .sem_req  (chk_sem_req)
    );

    // combinational read-back
    always_comb begin
        cfg_rdata = '0;
        if (hit_mst) begin
            cfg_rdata[LOCK_POS]  = mst_tab[mst_idx].lock;
            cfg_rdata[DOM_W-1:0] = mst_tab[mst_idx].dom;
        end else if (hit_pol) begin
            cfg_rdata[LOCK_POS]  = pol_tab[pol_idx].lock;
            cfg_rdata[SEM_POS]   = pol_tab[pol_idx].sem;
            cfg_rdata[POL_W-1:0] = pol_tab[pol_idx].perm;
        end else if (hit_stat) begin
            cfg_rdata[DOM_W-1:0] = mst_tab[cfg_mid].dom;
        end
    end
endmodule

// File: rtl/domain_access_checker_sva.sv
`timescale 1ns/1ps
module domain_access_checker_sva
    import dac_pkg::*;
#(
    parameter int N_MASTERS = 8,
    parameter int N_PERIPH  = 16,
    parameter int AW        = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cfg_we,
    input logic [AW-1:0]            cfg_addr,
    input logic [REG_W-1:0]         cfg_rdata,
    input mst_ent_t [N_MASTERS-1:0] mst_tab,
    input pol_ent_t [N_PERIPH-1:0]  pol_tab
);
    localparam int STAT_ADDR = N_MASTERS + N_PERIPH;

    for (genvar i = 0; i < N_MASTERS; i++) begin : g_mst
        a_r4_mst_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            mst_tab[i].lock |=> mst_tab[i].lock && $stable(mst_tab[i].dom));
    end

    for (genvar i = 0; i < N_PERIPH; i++) begin : g_pol
        a_r5_pol_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            pol_tab[i].lock |=> $stable(pol_tab[i]));
    end

    a_r10_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(mst_tab) && $stable(pol_tab)));

    a_r10_mst_write_spares_policy: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (int'(cfg_addr) < N_MASTERS)) |=> $stable(pol_tab));

    a_r9_stat_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (int'(cfg_addr) >= STAT_ADDR)) |=> ($stable(mst_tab) && $stable(pol_tab)));

    a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cfg_addr) > STAT_ADDR) |-> (cfg_rdata == '0));

    a_r9_stat_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cfg_addr) == STAT_ADDR) |-> (cfg_rdata[REG_W-1:DOM_W] == '0));
endmodule

bind domain_access_checker domain_access_checker_sva #(
    .N_MASTERS (N_MASTERS),
    .N_PERIPH  (N_PERIPH),
    .AW        (AW)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata),
    .mst_tab   (mst_tab),
    .pol_tab   (pol_tab)
);

// File: tb/sim_domain_access_checker.sv
`timescale 1ns/1ps
module sim_domain_access_checker;
    localparam int NM   = 8;
    localparam int NP   = 16;
    localparam int AW   = 5;
    localparam int STAT = 24;
    localparam int PB   = 8;   // first policy address

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [2:0]  cfg_mid = '0;
    logic [31:0] cfg_rdata;
    logic [2:0]  chk_mid = '0;
    logic [3:0]  chk_pidx = '0;
    logic        chk_write = 1'b0;
    logic        chk_allow;
    logic        chk_sem_req;

    always #4 clk = ~clk;

    domain_access_checker u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_mid(cfg_mid), .cfg_rdata(cfg_rdata),
        .chk_mid(chk_mid), .chk_pidx(chk_pidx), .chk_write(chk_write),
        .chk_allow(chk_allow), .chk_sem_req(chk_sem_req)
    );

    // scoreboard item: kind 0 = cfg_rdata, 1 = chk_allow, 2 = chk_sem_req
    typedef struct {
        int          req;
        int          kind;
        logic [31:0] exp;
    } item_t;

    item_t sbq[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;

    // monitor: compares every queued expectation at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sbq.size() > 0) begin
                item_t       it;
                logic [31:0] act;
                it = sbq.pop_front();
                case (it.kind)
                    0:       act = cfg_rdata;
                    1:       act = {31'b0, chk_allow};
                    default: act = {31'b0, chk_sem_req};
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL R%0d kind=%0d actual=%08h expected=%08h", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic cfg_wr(input int a, input logic [31:0] d);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic exp_rd(input int req, input int a, input logic [31:0] e);
        @(posedge clk); #1;
        cfg_addr = AW'(a);
        sbq.push_back('{req, 0, e});
        @(negedge clk); #1;
    endtask

    task automatic exp_stat(input int req, input int mid, input logic [31:0] e);
        @(posedge clk); #1;
        cfg_addr = AW'(STAT); cfg_mid = 3'(mid);
        sbq.push_back('{req, 0, e});
        @(negedge clk); #1;
    endtask

    task automatic exp_chk(input int req, input int mid, input int p, input logic wr,
                           input logic allow_e, input logic sem_e);
        @(posedge clk); #1;
        chk_mid = 3'(mid); chk_pidx = 4'(p); chk_write = wr;
        sbq.push_back('{req, 1, {31'b0, allow_e}});
        sbq.push_back('{req, 2, {31'b0, sem_e}});
        @(negedge clk); #1;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    // watchdog
    initial begin
        #(8 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL R0 watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset contents of both tables
        for (int m = 0; m < NM; m++) exp_rd(1, m, 32'h0);
        for (int p = 0; p < NP; p++) exp_rd(1, PB + p, 32'h0000_00FF);
        // R1: default allows read and write, no semaphore
        exp_chk(1, 3, 5, 1'b0, 1'b1, 1'b0);
        exp_chk(1, 7, 15, 1'b1, 1'b1, 1'b0);

        // R2: master 1 -> domain 2, junk bits dropped
        cfg_wr(1, 32'h0000_F0F2);
        exp_rd(2, 1, 32'h0000_0002);
        // R10: neighbours untouched
        exp_rd(10, 0, 32'h0);
        exp_rd(10, 2, 32'h0);
        exp_rd(10, PB + 5, 32'h0000_00FF);

        // R3: p4: d0=WO, d2=RO, semaphore set
        cfg_wr(PB + 4, 32'h4000_0021);
        exp_rd(3, PB + 4, 32'h4000_0021);
        // R3: p6: d0=none, d1=WO, d2=RO, d3=RW, reserved bits dropped
        cfg_wr(PB + 6, 32'h3FFF_FFE4);
        exp_rd(3, PB + 6, 32'h0000_00E4);

        // R6 / R8: master 1 in domain 2 sees read-only on p4
        exp_chk(6, 1, 4, 1'b0, 1'b1, 1'b1);
        exp_chk(6, 1, 4, 1'b1, 1'b0, 1'b1);
        // R6 / R8: master 0 in domain 0 sees write-only on p4
        exp_chk(6, 0, 4, 1'b0, 1'b0, 1'b1);
        exp_chk(8, 0, 4, 1'b1, 1'b1, 1'b1);
        // R6: code 0 denies both
        exp_chk(6, 0, 6, 1'b0, 1'b0, 1'b0);
        exp_chk(6, 0, 6, 1'b1, 1'b0, 1'b0);

        // R7: master 2 joins domain 2, same answers as master 1
        cfg_wr(2, 32'h0000_0002);
        exp_chk(7, 2, 4, 1'b0, 1'b1, 1'b1);
        exp_chk(7, 2, 4, 1'b1, 1'b0, 1'b1);
        // R7: move master 2 to domain 3
        cfg_wr(2, 32'h0000_0003);
        exp_chk(7, 2, 4, 1'b0, 1'b0, 1'b1);
        exp_chk(7, 2, 6, 1'b1, 1'b1, 1'b0);
        exp_chk(7, 1, 4, 1'b0, 1'b1, 1'b1);

        // R4: lock master 3 in domain 1
        cfg_wr(3, 32'h8000_0001);
        exp_rd(4, 3, 32'h8000_0001);
        cfg_wr(3, 32'h0000_0003);
        exp_rd(4, 3, 32'h8000_0001);
        cfg_wr(3, 32'h0000_0000);
        exp_rd(4, 3, 32'h8000_0001);
        exp_chk(4, 3, 6, 1'b1, 1'b1, 1'b0);
        exp_chk(4, 3, 6, 1'b0, 1'b0, 1'b0);

        // R5: lock p7 with only domain 0 granted
        cfg_wr(PB + 7, 32'h8000_0003);
        exp_rd(5, PB + 7, 32'h8000_0003);
        cfg_wr(PB + 7, 32'h4000_00FF);
        exp_rd(5, PB + 7, 32'h8000_0003);
        exp_chk(5, 0, 7, 1'b0, 1'b1, 1'b0);
        exp_chk(5, 3, 7, 1'b0, 1'b0, 1'b0);

        // R9: status reports the domain of cfg_mid
        exp_stat(9, 3, 32'h0000_0001);
        exp_stat(9, 1, 32'h0000_0002);
        exp_stat(9, 0, 32'h0000_0000);
        cfg_wr(STAT, 32'hFFFF_FFFF);
        exp_stat(9, 0, 32'h0000_0000);
        exp_rd(9, 0, 32'h0);
        cfg_wr(30, 32'hFFFF_FFFF);
        exp_rd(9, 30, 32'h0);
        exp_rd(9, 25, 32'h0);
        exp_rd(9, PB + 4, 32'h4000_0021);
        exp_rd(9, PB + 0, 32'h0000_00FF);

        // R1 / R4: reset clears locks and contents
        do_reset();
        exp_rd(1, 3, 32'h0);
        exp_rd(1, PB + 7, 32'h0000_00FF);
        cfg_wr(3, 32'h0000_0002);
        exp_rd(4, 3, 32'h0000_0002);
        cfg_wr(PB + 7, 32'h0000_0000);
        exp_rd(5, PB + 7, 32'h0000_0000);

        @(posedge clk);
        @(negedge clk); #1;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule